// File: doc/BRIEF.md
# Frame-Locked Line Pulse and Clamp Generator

This block produces a periodic line waveform and a short clamp pulse. The line waveform comes from a free-running counter on the system clock. One programmable compare value marks the end of each line period. When the counter matches it, the counter returns to zero and the line output goes high. A second compare value marks the point in the period where the line output goes low again.

An external frame signal keeps the line waveform in step with a slower frame waveform. A rising edge on that signal does the same thing as a period match: the counter restarts and the line output goes high. For the line period to stay constant from frame to frame, the frame period must be an exact multiple of the line period. The block does not check this; that is the integrator's job.

After every falling edge of the line output, a clamp pulse of fixed width is issued. It is typically used to gate black-level restoration at the start of each line's active region.

Top module: `line_sync_gen`

## Requirements
- R1: When no restart occurs in a cycle, the internal counter advances by exactly one (modulo 2^CNT_W). With a free-running period compare value P, the line output therefore rises every P+1 cycles.
- R2: If the counter equals `period_cmp` at a clock edge, then after that edge the counter is zero and `line_out` is 1.
- R3: If the counter equals `drop_cmp` at a clock edge and no restart occurs at that edge, then `line_out` is 0 after the edge.
- R4: A rising edge on `frame_sync` causes a restart at the next clock edge, identical to a period match. A rising edge means the input is sampled high at an edge after being sampled low at the previous edge. A restart sets the counter to zero and drives `line_out` to 1.
- R5: Holding `frame_sync` high causes only one restart. Further cycles with the input high have no effect until it has been sampled low again.
- R6: `clamp_out` goes to 1 one cycle after the first cycle in which `line_out` is seen low following a high cycle.
- R7: Without a retrigger, `clamp_out` stays at 1 for exactly CLAMP_LEN cycles (default 6) and then returns to 0.
- R8: While `rst` is high, the counter is held at zero, both outputs are 0, and the recorded `frame_sync` history is low.
- R9: A `frame_sync` rising edge in the same cycle as a period match produces one single restart. The period that follows is not shortened or shifted.
- R10: When `period_cmp` and `drop_cmp` both match in the same cycle, the restart wins and `line_out` is 1.
- R11: A new falling edge of `line_out` while `clamp_out` is still high restarts the full CLAMP_LEN window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| period_cmp | input | CNT_W | Count at which the period ends (restart and line high) |
| drop_cmp | input | CNT_W | Count at which the line output goes low |
| frame_sync | input | 1 | Frame level input; its rising edge forces a restart |
| line_out | output | 1 | Line waveform |
| clamp_out | output | 1 | Clamp pulse following each line fall |

## Verification
The hardest case to reach from the ports is a frame edge that lands in exactly the cycle where the counter matches the period value. The counter cannot be seen from outside. The driver therefore keeps its own cycle model of the counter, waits until that model reports a match, and raises `frame_sync` in that same cycle. It then keeps the level high for many cycles, so that R9 and R5 are covered in one run. Clamp retriggering (R11) is reached by choosing a line period shorter than the clamp width. This makes each new fall arrive while the previous clamp is still high.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

    // Which source caused a period restart in a given cycle
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_PERIOD = 2'd1,
        CAUSE_SYNC   = 2'd2,
        CAUSE_BOTH   = 2'd3
    } restart_cause_e;

    // Polarity selection for the shared edge detector
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    // Decoded per-cycle action of the line timer
    typedef struct packed {
        restart_cause_e cause;
        logic           restart;
        logic           drop;
    } line_evt_t;

    // Merge the three hit sources. A restart always dominates a drop, and
    // two simultaneous restart sources still form one restart.
    function automatic line_evt_t resolve_event(input logic period_hit,
                                                input logic sync_hit,
                                                input logic drop_hit);
        line_evt_t e;
        e.cause   = restart_cause_e'({sync_hit, period_hit});
        e.restart = period_hit | sync_hit;
        e.drop    = drop_hit & ~(period_hit | sync_hit);
        return e;
    endfunction

endpackage

// File: rtl/lsg_edge_detect.sv
module lsg_edge_detect
    import lsg_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic edge_o
);

    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= level_i;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign edge_o = level_i & ~hist_q;
        end else begin : g_fall
            assign edge_o = ~level_i & hist_q;
        end
    endgenerate

    // R5: an edge is reported for one cycle only while the level holds
    p_single_edge_r5: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);

endmodule

// File: rtl/lsg_line_timer.sv
module lsg_line_timer
    import lsg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_cmp,
    input  logic [CNT_W-1:0] drop_cmp,
    input  logic             sync_rise,
    output logic             line_o
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             line_q, line_d;
    line_evt_t        evt;

    always_comb evt = resolve_event(cnt_q == period_cmp, sync_rise, cnt_q == drop_cmp);

    always_comb begin
        cnt_d  = evt.restart ? '0 : cnt_q + 1'b1;
        line_d = line_q;
        if (evt.restart)   line_d = 1'b1;
        else if (evt.drop) line_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            line_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            line_q <= line_d;
        end
    end

    assign line_o = line_q;

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != period_cmp && !sync_rise) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    p_period_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == period_cmp) |=> (cnt_q == '0 && line_q));

    p_drop_low_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == drop_cmp && cnt_q != period_cmp && !sync_rise) |=> !line_q);

    p_sync_clear_r4: assert property (@(posedge clk) disable iff (rst)
        sync_rise |=> (cnt_q == '0 && line_q));

    p_both_single_r9: assert property (@(posedge clk) disable iff (rst)
        (evt.cause == CAUSE_BOTH) |=> (cnt_q == '0 && line_q));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == period_cmp && cnt_q == drop_cmp) |=> line_q);

endmodule

// File: rtl/lsg_clamp_pulse.sv
module lsg_clamp_pulse #(
    parameter int CLAMP_LEN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger_i,
    output logic clamp_o
);

    localparam int CW = $clog2(CLAMP_LEN + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (trigger_i)      left_q <= CW'(CLAMP_LEN);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign clamp_o = (left_q != '0);

    // Checker-only run length since the last trigger
    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)            run_q <= '0;
        else if (trigger_i) run_q <= (CW+1)'(1);
        else if (clamp_o)   run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    p_clamp_rise_r6: assert property (@(posedge clk) disable iff (rst)
        trigger_i |=> clamp_o);

    p_clamp_width_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(clamp_o) |-> $past(run_q) == (CW+1)'(CLAMP_LEN));

    p_retrigger_r11: assert property (@(posedge clk) disable iff (rst)
        (trigger_i && clamp_o) |=> clamp_o);

endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen
    import lsg_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int CLAMP_LEN = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_cmp,
    input  logic [CNT_W-1:0] drop_cmp,
    input  logic             frame_sync,
    output logic             line_out,
    output logic             clamp_out
);

    logic sync_rise;
    logic line_fall;
    logic line_w;

    lsg_edge_detect #(.KIND(EDGE_RISE)) u_sync_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (frame_sync),
        .edge_o  (sync_rise)
    );

    lsg_line_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .period_cmp (period_cmp),
        .drop_cmp   (drop_cmp),
        .sync_rise  (sync_rise),
        .line_o     (line_w)
    );

    lsg_edge_detect #(.KIND(EDGE_FALL)) u_line_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (line_w),
        .edge_o  (line_fall)
    );

    lsg_clamp_pulse #(.CLAMP_LEN(CLAMP_LEN)) u_clamp (
        .clk       (clk),
        .rst       (rst),
        .trigger_i (line_fall),
        .clamp_o   (clamp_out)
    );

    assign line_out = line_w;

    // R6: clamp follows a line fall, never precedes it
    p_clamp_after_fall_r6: assert property (@(posedge clk) disable iff (rst)
        line_fall |=> clamp_out);

endmodule

// File: tb/test_line_sync_gen.sv
module test_line_sync_gen;

    localparam int CNT_W     = 8;
    localparam int CLAMP_LEN = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] period_cmp = '0;
    logic [CNT_W-1:0] drop_cmp = '0;
    logic             frame_sync = 1'b0;
    logic             line_out;
    logic             clamp_out;

    line_sync_gen #(.CNT_W(CNT_W), .CLAMP_LEN(CLAMP_LEN)) i_line_sync_gen (
        .clk        (clk),
        .rst        (rst),
        .period_cmp (period_cmp),
        .drop_cmp   (drop_cmp),
        .frame_sync (frame_sync),
        .line_out   (line_out),
        .clamp_out  (clamp_out)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic  line;
        logic  clamp;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    // Requirement-level cycle model
    int m_cnt;
    bit m_line, m_line_d, m_sync_prev;
    int m_left;

    task automatic model_reset();
        m_cnt = 0; m_line = 0; m_line_d = 0; m_sync_prev = 0; m_left = 0;
    endtask

    // Called at a negedge with inputs already set; predicts the next edge
    task automatic step(input string tag);
        bit rise, restart, n_line;
        int n_cnt, n_left;
        rise    = frame_sync && !m_sync_prev;
        restart = (m_cnt == int'(period_cmp)) || rise;
        n_line  = restart ? 1'b1 : ((m_cnt == int'(drop_cmp)) ? 1'b0 : m_line);
        n_cnt   = restart ? 0 : (m_cnt + 1) % (1 << CNT_W);
        n_left  = (m_line_d && !m_line) ? CLAMP_LEN : ((m_left > 0) ? m_left - 1 : 0);
        m_line_d    = m_line;
        m_line      = n_line;
        m_cnt       = n_cnt;
        m_left      = n_left;
        m_sync_prev = frame_sync;
        exp_q.push_back('{n_line, (n_left != 0), tag});
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic check_direct(input logic act_l, input logic act_c, input string tag);
        checks++;
        if (act_l !== 1'b0 || act_c !== 1'b0) begin
            errors++;
            $display("FAIL %s: line=%0b clamp=%0b expected line=0 clamp=0", tag, act_l, act_c);
        end
    endtask

    // R8: reset holds outputs low; inputs set before release
    task automatic do_reset(input int p, input int d);
        rst = 1'b1;
        frame_sync = 1'b0;
        period_cmp = CNT_W'(p);
        drop_cmp   = CNT_W'(d);
        repeat (3) @(negedge clk);
        check_direct(line_out, clamp_out, "R8 reset state");
        model_reset();
        rst = 1'b0;
    endtask

    // Monitor: compare predicted values after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (line_out !== e.line || clamp_out !== e.clamp) begin
                    errors++;
                    $display("FAIL %s: line=%0b clamp=%0b expected line=%0b clamp=%0b",
                             e.tag, line_out, clamp_out, e.line, e.clamp);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);

        // R1 R2 R3: free run, period 10 cycles, drop at count 4
        do_reset(9, 4);
        run(45, "R1 R2 R3 free run");

        // R6 R7: longer period so the clamp completes between falls
        do_reset(20, 5);
        run(60, "R6 R7 clamp width");

        // R4: a frame edge part way through a period
        do_reset(40, 20);
        run(15, "R4 before edge");
        frame_sync = 1'b1;
        step("R4 sync edge");
        frame_sync = 1'b0;
        run(50, "R4 after edge");

        // R9 and R5: edge coincident with a period match, then level held
        do_reset(12, 5);
        run(20, "R9 lead in");
        while (m_cnt != int'(period_cmp)) step("R9 align");
        frame_sync = 1'b1;
        step("R9 coincident edge");
        run(40, "R5 level held high");
        frame_sync = 1'b0;
        run(3, "R5 level low");
        frame_sync = 1'b1;
        step("R4 second edge");
        run(20, "R4 after second edge");
        frame_sync = 1'b0;

        // R10: period and drop values equal
        do_reset(7, 7);
        run(30, "R10 set wins");

        // R11: falls every 4 cycles retrigger the clamp
        do_reset(3, 1);
        run(30, "R11 retrigger");

        // R3 R7: drop near the period end, full clamp after each fall
        do_reset(15, 14);
        run(40, "R3 R7 late drop");

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule